// File: doc/BRIEF.md
# Serializing Atomic Memory Operation Unit

This unit sits beside a small word-addressed store and accepts read-modify-write requests from several requester ports. It runs them strictly one after another, so any two operations on the same word can never interleave. Each requester can ask for one of four operations: a plain load, a plain store, a test-and-set, or a fetch-and-increment. Every operation returns the value the word held before the operation.

Lock software uses the unit in a simple way. A word holding 0 is a free lock and a word holding 1 is a busy lock. A test-and-set that returns 0 means the caller now owns the lock. Ticket counters use fetch-and-increment, which wraps modulo a configurable power of two.

All atomics act on the backing store itself. Every operation that writes the store sends out an invalidate for its address, together with the number of the source port, so that requesters can drop their cached copies. A test-and-set on a word that already holds 1 still sends this invalidate. A requester holds its request valid until it sees its one-cycle response, then drops it.

Top module: `amo_serial_unit`

## Requirements
- R1: After reset no response or invalidate is asserted, and every word of the store reads as 0.
- R2: A test-and-set (opcode 2'b10) returns the word's previous content and leaves the word holding 1.
- R3: A test-and-set returns 0 only when the word was free (0). A test-and-set on a busy word (1) returns 1, and it raises an invalidate just as a successful one does.
- R4: A fetch-and-increment (opcode 2'b11) returns the old value and stores (old + 1) mod 2^WRAP_W, with the bits above WRAP_W cleared.
- R5: A store (opcode 2'b01) returns the old value, writes the full write data, and raises an invalidate.
- R6: A load (opcode 2'b00) returns the word's value, leaves the word unchanged and raises no invalidate.
- R7: At most one response is asserted in any cycle, and two responses are at least three cycles apart.
- R8: Waiting requests are served in round-robin order. The port after the last served port has the highest priority, and port 0 is first after reset.
- R9: An invalidate is asserted in the same cycle as the response of the operation that caused it. It carries that operation's address and source port.
- R10: On an idle unit a request is answered after exactly three rising clock edges. With requests waiting back to back, each further response follows the previous one by exactly three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_PORTS | Per-port request, held until the port's response |
| req_op | input | 2*N_PORTS | Per-port opcode: 00 load, 01 store, 10 test-and-set, 11 fetch-and-increment |
| req_addr | input | ADDR_W*N_PORTS | Per-port word address |
| req_wdata | input | DATA_W*N_PORTS | Per-port store data |
| rsp_valid | output | N_PORTS | One-cycle per-port response strobe |
| rsp_data | output | DATA_W*N_PORTS | Per-port old value of the word, valid with rsp_valid |
| inv_valid | output | 1 | Invalidate broadcast strobe |
| inv_addr | output | ADDR_W | Address being invalidated |
| inv_src | output | PID_W | Port whose operation caused the invalidate |

## Verification
The bench sends all four ports at one lock word with test-and-set. A unit that merged the read and the write would hand the lock to more than one port. A unit that skipped the invalidate on a busy word would leave the losing requesters silent. The bench stores the top counter value and then increments it, so a unit without the wrap would return a nonzero value on the next load. Random rounds with overlapping port subsets and colliding addresses check the round-robin order and the three-cycle spacing. A unit that re-granted the port it had just answered, or that let two operations overlap, would break that order and spacing.

// File: rtl/amo_pkg.sv
// Shared opcode and sequencer types for the atomic serializing unit.
// Assumes a 2-bit opcode per request port.
package amo_pkg;
    typedef enum logic [1:0] {
        AMO_LOAD  = 2'b00,
        AMO_STORE = 2'b01,
        AMO_TAS   = 2'b10,
        AMO_FINC  = 2'b11
    } amo_op_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'b00,
        SEQ_READ  = 2'b01,
        SEQ_WRITE = 2'b10
    } seq_state_e;
endpackage

// File: rtl/amo_rr_arbiter.sv
// Round-robin arbiter: the port after the last winner has top priority.
// Assumes N_PORTS >= 2. The pointer advances only when adv is high.
module amo_rr_arbiter #(
    parameter int N_PORTS = 4,
    parameter int PID_W   = $clog2(N_PORTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] req,
    input  logic               adv,
    output logic               gnt_any,
    output logic [PID_W-1:0]   gnt_idx
);
    logic [PID_W-1:0] last_q;

    // Search from last+N down to last+1 so that the nearest requester wins.
    always_comb begin
        int idx;
        gnt_any = 1'b0;
        gnt_idx = last_q;
        for (int k = N_PORTS; k >= 1; k--) begin
            idx = (int'(last_q) + k) % N_PORTS;
            if (req[idx]) begin
                gnt_any = 1'b1;
                gnt_idx = PID_W'(idx);
            end
        end
    end

    // Remember the last winner; after reset port 0 comes first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= PID_W'(N_PORTS - 1);
        else if (adv && gnt_any)
            last_q <= gnt_idx;
    end
endmodule

// File: rtl/amo_word_store.sv
// Small word store: combinational read, one synchronous write port.
// Assumes a depth of 2**ADDR_W words, all cleared by reset.
module amo_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Read port.
    assign rdata = words[raddr];

    // Clear on reset, otherwise apply the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                words[i] <= '0;
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/amo_alu.sv
// Computes the new word value and side effects for one atomic operation.
// Assumes WRAP_W <= DATA_W; increments wrap modulo 2**WRAP_W.
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WRAP_W = 4
) (
    input  amo_op_e           op,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] new_val,
    output logic              wr_en,
    output logic              inv_en
);
    localparam logic [DATA_W-1:0] WRAP_MASK = DATA_W'((1 << WRAP_W) - 1);

    // Select the new value per opcode; every writing opcode also invalidates.
    always_comb begin
        new_val = old_val;
        wr_en   = 1'b1;
        unique case (op)
            AMO_LOAD:  wr_en   = 1'b0;
            AMO_STORE: new_val = wdata;
            AMO_TAS:   new_val = DATA_W'(1);
            AMO_FINC:  new_val = (old_val + DATA_W'(1)) & WRAP_MASK;
            default:   wr_en   = 1'b0;
        endcase
        inv_en = wr_en;
    end
endmodule

// File: rtl/amo_serial_unit.sv
// Serializing atomic unit: one round-robin winner at a time runs
// grant -> read -> write/respond. Requesters hold req_valid until their
// response and may drop it in the response cycle. The port being answered
// is left out of arbitration in that cycle.
module amo_serial_unit
    import amo_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int WRAP_W  = 4,
    parameter int PID_W   = $clog2(N_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          req_valid,
    input  logic [2*N_PORTS-1:0]        req_op,
    input  logic [ADDR_W*N_PORTS-1:0]   req_addr,
    input  logic [DATA_W*N_PORTS-1:0]   req_wdata,
    output logic [N_PORTS-1:0]          rsp_valid,
    output logic [DATA_W*N_PORTS-1:0]   rsp_data,
    output logic                        inv_valid,
    output logic [ADDR_W-1:0]           inv_addr,
    output logic [PID_W-1:0]            inv_src
);
    seq_state_e         state;
    amo_op_e            cur_op;
    logic [PID_W-1:0]   cur_port;
    logic [ADDR_W-1:0]  cur_addr;
    logic [DATA_W-1:0]  cur_wdata;
    logic [DATA_W-1:0]  old_q;
    logic [DATA_W-1:0]  mem_rdata;
    logic [DATA_W-1:0]  alu_new;
    logic               alu_we;
    logic               alu_inv;
    logic               gnt_any;
    logic [PID_W-1:0]   gnt_idx;
    logic [N_PORTS-1:0] arb_req;

    // The port that is seeing its response this cycle does not compete.
    assign arb_req = req_valid & ~rsp_valid;

    amo_rr_arbiter #(.N_PORTS(N_PORTS), .PID_W(PID_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (arb_req),
        .adv     (state == SEQ_IDLE),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx)
    );

    amo_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (cur_addr),
        .rdata (mem_rdata),
        .we    ((state == SEQ_WRITE) && alu_we),
        .waddr (cur_addr),
        .wdata (alu_new)
    );

    amo_alu #(.DATA_W(DATA_W), .WRAP_W(WRAP_W)) u_alu (
        .op      (cur_op),
        .old_val (old_q),
        .wdata   (cur_wdata),
        .new_val (alu_new),
        .wr_en   (alu_we),
        .inv_en  (alu_inv)
    );

    // Three-step sequencer; the response and invalidate strobes last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            cur_op    <= AMO_LOAD;
            cur_port  <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            old_q     <= '0;
            rsp_valid <= '0;
            rsp_data  <= '0;
            inv_valid <= 1'b0;
            inv_addr  <= '0;
            inv_src   <= '0;
        end else begin
            rsp_valid <= '0;
            inv_valid <= 1'b0;
            unique case (state)
                SEQ_IDLE: if (gnt_any) begin
                    cur_port  <= gnt_idx;
                    cur_op    <= amo_op_e'(req_op[2*gnt_idx +: 2]);
                    cur_addr  <= req_addr[ADDR_W*gnt_idx +: ADDR_W];
                    cur_wdata <= req_wdata[DATA_W*gnt_idx +: DATA_W];
                    state     <= SEQ_READ;
                end
                SEQ_READ: begin
                    old_q <= mem_rdata;
                    state <= SEQ_WRITE;
                end
                SEQ_WRITE: begin
                    rsp_valid[cur_port]                <= 1'b1;
                    rsp_data[DATA_W*cur_port +: DATA_W] <= old_q;
                    inv_valid                          <= alu_inv;
                    inv_addr                           <= cur_addr;
                    inv_src                            <= cur_port;
                    state                              <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/amo_serial_chk.sv
// Property checker for amo_serial_unit, attached through bind.
// Assumes the response and invalidate are one-cycle strobes.
module amo_serial_chk
    import amo_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int PID_W   = $clog2(N_PORTS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_PORTS-1:0] rsp_valid,
    input logic               inv_valid,
    input logic [PID_W-1:0]   inv_src,
    input logic [1:0]         cur_op
);
    // R7
    single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

    // R7
    rsp_gap1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_valid) |=> !(|rsp_valid));

    // R7
    rsp_gap2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_valid) |=> ##1 !(|rsp_valid));

    // R9
    inv_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> rsp_valid[inv_src]);

    // R6
    load_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rsp_valid) && cur_op == AMO_LOAD) |-> !inv_valid);

    // R3
    tas_always_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rsp_valid) && cur_op == AMO_TAS) |-> inv_valid);
endmodule

bind amo_serial_unit amo_serial_chk #(.N_PORTS(N_PORTS), .PID_W(PID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .inv_valid (inv_valid),
    .inv_src   (inv_src),
    .cur_op    (cur_op)
);

// File: tb/tb_amo_serial_unit.sv
// Self-checking bench: directed lock/counter cases plus seeded random rounds.
module tb_amo_serial_unit;
    localparam int N      = 4;
    localparam int AW     = 4;
    localparam int DW     = 8;
    localparam int WW     = 4;
    localparam int PW     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req_valid = '0;
    logic [2*N-1:0]    req_op = '0;
    logic [AW*N-1:0]   req_addr = '0;
    logic [DW*N-1:0]   req_wdata = '0;
    logic [N-1:0]      rsp_valid;
    logic [DW*N-1:0]   rsp_data;
    logic              inv_valid;
    logic [AW-1:0]     inv_addr;
    logic [PW-1:0]     inv_src;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [DW-1:0] model [1<<AW];
    int            rr_last = N - 1;
    logic [1:0]    r_op   [N];
    logic [AW-1:0] r_addr [N];
    logic [DW-1:0] r_wd   [N];

    amo_serial_unit #(.N_PORTS(N), .ADDR_W(AW), .DATA_W(DW), .WRAP_W(WW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .inv_valid(inv_valid), .inv_addr(inv_addr),
        .inv_src(inv_src)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_new(input logic [1:0] op, input logic [DW-1:0] old,
                                             input logic [DW-1:0] wd);
        case (op)
            2'b00:   return old;
            2'b01:   return wd;
            2'b10:   return DW'(1);
            default: return (old + DW'(1)) & DW'((1 << WW) - 1);
        endcase
    endfunction

    function automatic int rr_next(input logic [N-1:0] pend, input int last);
        for (int k = 1; k <= N; k++)
            if (pend[(last + k) % N]) return (last + k) % N;
        return -1;
    endfunction

    // Issue the ports in mask together and check each response as it arrives.
    task automatic run_round(input logic [N-1:0] mask, input string load_tag);
        logic [N-1:0] pend;
        int since;
        @(negedge clk);
        for (int p = 0; p < N; p++) begin
            req_op[2*p +: 2]     = r_op[p];
            req_addr[AW*p +: AW] = r_addr[p];
            req_wdata[DW*p +: DW] = r_wd[p];
        end
        req_valid = mask;
        pend  = mask;
        since = 0;
        while (pend != '0 && since < 40) begin
            @(posedge clk);
            @(negedge clk);
            since++;
            if (rsp_valid != '0) begin
                int p;
                logic [DW-1:0] old;
                string dtag;
                p = rr_next(pend, rr_last);
                chk("R7 onehot response", 32'($countones(rsp_valid)), 32'd1);
                chk("R8 round-robin port", 32'(rsp_valid), 32'(1 << p));
                chk("R10 response spacing", 32'(since), 32'd3);
                old = model[r_addr[p]];
                case (r_op[p])
                    2'b00:   dtag = load_tag;
                    2'b01:   dtag = "R5 store old value";
                    2'b10:   dtag = "R2 tas old value";
                    default: dtag = "R4 finc old value";
                endcase
                chk(dtag, 32'(rsp_data[DW*p +: DW]), 32'(old));
                if (r_op[p] == 2'b00) begin
                    chk("R6 load no invalidate", 32'(inv_valid), 32'd0);
                end else begin
                    chk(r_op[p] == 2'b10 ? "R3 tas invalidate" : "R9 invalidate",
                        32'(inv_valid), 32'd1);
                    chk("R9 invalidate address", 32'(inv_addr), 32'(r_addr[p]));
                    chk("R9 invalidate source", 32'(inv_src), 32'(p));
                end
                model[r_addr[p]] = exp_new(r_op[p], old, r_wd[p]);
                rr_last = p;
                pend[p] = 1'b0;
                req_valid[p] = 1'b0;
                since = 0;
            end else begin
                chk("R9 no invalidate without response", 32'(inv_valid), 32'd0);
            end
        end
        chk("R10 round completed", 32'(pend), 32'd0);
        req_valid = '0;
    endtask

    task automatic set_port(input int p, input logic [1:0] op, input logic [AW-1:0] a,
                            input logic [DW-1:0] wd);
        r_op[p] = op; r_addr[p] = a; r_wd[p] = wd;
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        for (int p = 0; p < N; p++) set_port(p, 2'b00, '0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: nothing strobing after reset
        chk("R1 rsp idle after reset", 32'(rsp_valid), 32'd0);
        chk("R1 inv idle after reset", 32'(inv_valid), 32'd0);

        // R1: all words read as zero
        for (int b = 0; b < (1 << AW); b += N) begin
            for (int p = 0; p < N; p++) set_port(p, 2'b00, AW'(b + p), '0);
            run_round('1, "R1 word cleared by reset");
        end

        // R3: four-way test-and-set race on one lock word, exactly one winner
        for (int p = 0; p < N; p++) set_port(p, 2'b10, AW'(5), '0);
        run_round('1, "R6 load value");
        set_port(0, 2'b00, AW'(5), '0);
        run_round(4'b0001, "R2 word holds 1 after tas");

        // R4: counter wrap at 2**WRAP_W
        set_port(1, 2'b01, AW'(7), DW'((1 << WW) - 1));
        run_round(4'b0010, "R6 load value");
        set_port(2, 2'b11, AW'(7), '0);
        run_round(4'b0100, "R6 load value");
        set_port(3, 2'b00, AW'(7), '0);
        run_round(4'b1000, "R4 wrapped to zero");
        // R4: upper bits cleared on increment
        set_port(0, 2'b01, AW'(8), 8'hAB);
        set_port(1, 2'b11, AW'(8), '0);
        set_port(2, 2'b00, AW'(8), '0);
        run_round(4'b0111, "R4 upper bits cleared");

        // Random rounds: mixed ops, colliding addresses, lock-like data
        for (int r = 0; r < 400; r++) begin
            logic [N-1:0] m;
            m = N'($urandom_range(1, (1 << N) - 1));
            for (int p = 0; p < N; p++)
                set_port(p, 2'($urandom_range(0, 3)), AW'($urandom_range(0, 5)),
                         ($urandom_range(0, 3) == 0) ? DW'($urandom) : DW'($urandom_range(0, 1)));
            run_round(m, "R6 load value");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule